// File: doc/BRIEF.md
# Direct-Store Segment Access Checker

This block gives the verdict on one memory access whose segment is marked for direct-store (I/O) use. Each request carries the access direction (read, write or instruction fetch), an access class code, a single protection key bit and the effective address. The block decides whether the access is granted, completes as a no-op, raises an exception, or is rejected as an internal error. For an exception it also forms the exception kind, the error code, the fault-status word and the captured fault address. A granted access passes the effective address through untranslated as the real address.

Requests enter on a valid/ready handshake. The verdict is registered and leaves on a second valid/ready handshake one cycle after acceptance. The block holds one result. When that result is stalled by `res_ready` low, `in_ready` drops, and the block accepts a new request only in a cycle where the held result is also taken. The verdict is computed entirely from the request, and no state carries over between requests.

Top module: `dsd_access_checker`

## Requirements
- R1: A fetch (`in_kind`=2'b10) always gives `res_exc`=1 (instruction storage) and `res_code`=32'h1000_0000, with every other word and flag zero. This applies to every class code.
- R2: A read (`in_kind`=2'b00) or write (`in_kind`=2'b01) with class 3'd1 (floating point) gives `res_exc`=3 (alignment) and `res_code`=ALIGN_FP_CODE (default 32'h0000_0010). `res_fault_addr` equals the effective address and `res_status` is zero.
- R3: A read or write with class 3'd2 (reserve/conditional) gives `res_exc`=2 (data storage) and `res_code`=0. `res_status` is 32'h0600_0000 for a write and 32'h0400_0000 for a read, and `res_fault_addr` equals the effective address.
- R4: A read or write with class 3'd4 (external control) gives `res_exc`=2. `res_status` is 32'h0610_0000 for a write and 32'h0410_0000 for a read, and `res_fault_addr` equals the effective address.
- R5: A read or write with class 3'd3 (cache management) gives `res_noop`=1 with no grant, no exception and all words zero.
- R6: A read or write with class 3'd0 (normal) is granted when (write or key≠1) and (read or key≠0) both hold. A read is therefore granted with key 0 and a write with key 1. A granted access gives `res_grant`=1 and `res_real_addr` equal to the effective address, with everything else zero.
- R7: A normal access that fails the rule in R6 gives `res_exc`=2 and `res_code`=0. `res_status` is 32'h0A00_0000 for a write and 32'h0800_0000 for a read, and `res_fault_addr` equals the effective address.
- R8: Class codes 3'd5 to 3'd7 on a read or write, and `in_kind`=2'b11 with any class, give `res_err`=1 with every other flag and word zero.
- R9: A request is accepted when `in_valid` and `in_ready` are both high, and `in_ready` = !`res_valid` || `res_ready`. The result appears with `res_valid` high in the next cycle. It stays unchanged with `res_valid` held high until a cycle in which `res_ready` is high.
- R10: After reset `res_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 illegal |
| in_class | input | 3 | Access class code |
| in_key | input | 1 | Protection key bit |
| in_eaddr | input | ADDR_W | Effective address |
| res_valid | output | 1 | Result present (done) |
| res_ready | input | 1 | Consumer takes the result |
| res_grant | output | 1 | Access granted |
| res_noop | output | 1 | Access completes as a no-op |
| res_err | output | 1 | Internal error: request not decodable |
| res_exc | output | 2 | 0 none, 1 instruction storage, 2 data storage, 3 alignment |
| res_code | output | 32 | Error code |
| res_status | output | 32 | Fault-status word |
| res_fault_addr | output | ADDR_W | Captured fault address |
| res_real_addr | output | ADDR_W | Real address on a grant |

## Verification
The assertions assume that `in_kind`, `in_class`, `in_key` and `in_eaddr` are settled whenever a request is accepted. They also assume that `res_ready` is a clean level, so that a stalled result is seen again in the next cycle. The bench changes inputs only away from the rising edge and draws every field from its full range, including the illegal direction and the unused class codes. It toggles `res_ready` at random so that stalls, back-to-back transfers and accept-while-draining cycles all occur.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_BAD   = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    CLS_NORMAL = 3'd0,
    CLS_FLOAT  = 3'd1,
    CLS_RESV   = 3'd2,
    CLS_CACHE  = 3'd3,
    CLS_EXTCTL = 3'd4
  } class_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_INSTR = 2'd1,
    EXC_DATA  = 2'd2,
    EXC_ALIGN = 2'd3
  } exc_e;

  typedef struct packed {
    logic              grant;
    logic              noop;
    logic              err;
    exc_e              exc;
    logic [WORD_W-1:0] code;
    logic [WORD_W-1:0] status;
    logic              capture;
    logic              pass;
  } verdict_t;

  localparam logic [WORD_W-1:0] CODE_FETCH_NX = 32'h1000_0000;
  localparam logic [WORD_W-1:0] ST_KEY_WR     = 32'h0A00_0000;
  localparam logic [WORD_W-1:0] ST_KEY_RD     = 32'h0800_0000;
  localparam logic [WORD_W-1:0] ST_RESV_WR    = 32'h0600_0000;
  localparam logic [WORD_W-1:0] ST_RESV_RD    = 32'h0400_0000;
  localparam logic [WORD_W-1:0] ST_EXT_WR     = 32'h0610_0000;
  localparam logic [WORD_W-1:0] ST_EXT_RD     = 32'h0410_0000;

endpackage

// File: rtl/dsd_verdict.sv
module dsd_verdict
  import dsd_pkg::*;
#(
  parameter logic [WORD_W-1:0] ALIGN_FP_CODE = 32'h0000_0010
) (
  input  logic [1:0] kind,
  input  logic [2:0] cls,
  input  logic       key,
  output verdict_t   verdict
);

  logic is_rd;
  logic is_wr;
  logic key_ok;

  assign is_rd  = (kind == KIND_READ);
  assign is_wr  = (kind == KIND_WRITE);
  assign key_ok = (is_wr || !key) && (is_rd || key);

  always_comb begin
    verdict = '0;
    if (kind == KIND_FETCH) begin
      verdict.exc  = EXC_INSTR;
      verdict.code = CODE_FETCH_NX;
    end else if (kind == KIND_BAD) begin
      verdict.err = 1'b1;
    end else begin
      case (cls)
        CLS_NORMAL: begin
          if (key_ok) begin
            verdict.grant = 1'b1;
            verdict.pass  = 1'b1;
          end else begin
            verdict.exc     = EXC_DATA;
            verdict.status  = is_wr ? ST_KEY_WR : ST_KEY_RD;
            verdict.capture = 1'b1;
          end
        end
        CLS_FLOAT: begin
          verdict.exc     = EXC_ALIGN;
          verdict.code    = ALIGN_FP_CODE;
          verdict.capture = 1'b1;
        end
        CLS_RESV: begin
          verdict.exc     = EXC_DATA;
          verdict.status  = is_wr ? ST_RESV_WR : ST_RESV_RD;
          verdict.capture = 1'b1;
        end
        CLS_CACHE: begin
          verdict.noop = 1'b1;
        end
        CLS_EXTCTL: begin
          verdict.exc     = EXC_DATA;
          verdict.status  = is_wr ? ST_EXT_WR : ST_EXT_RD;
          verdict.capture = 1'b1;
        end
        default: begin
          verdict.err = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/dsd_result_stage.sv
module dsd_result_stage
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  verdict_t          verdict,
  input  logic [ADDR_W-1:0] eaddr,
  input  logic              take,
  output logic              valid,
  output logic              grant,
  output logic              noop,
  output logic              err,
  output logic [1:0]        exc,
  output logic [WORD_W-1:0] code,
  output logic [WORD_W-1:0] status,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [ADDR_W-1:0] real_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      grant      <= 1'b0;
      noop       <= 1'b0;
      err        <= 1'b0;
      exc        <= EXC_NONE;
      code       <= '0;
      status     <= '0;
      fault_addr <= '0;
      real_addr  <= '0;
    end else begin
      valid <= load || (valid && !take);
      if (load) begin
        grant      <= verdict.grant;
        noop       <= verdict.noop;
        err        <= verdict.err;
        exc        <= verdict.exc;
        code       <= verdict.code;
        status     <= verdict.status;
        fault_addr <= verdict.capture ? eaddr : '0;
        real_addr  <= verdict.pass ? eaddr : '0;
      end
    end
  end

endmodule

// File: rtl/dsd_access_checker.sv
module dsd_access_checker
  import dsd_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter logic [WORD_W-1:0] ALIGN_FP_CODE = 32'h0000_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [2:0]        in_class,
  input  logic              in_key,
  input  logic [ADDR_W-1:0] in_eaddr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_grant,
  output logic              res_noop,
  output logic              res_err,
  output logic [1:0]        res_exc,
  output logic [WORD_W-1:0] res_code,
  output logic [WORD_W-1:0] res_status,
  output logic [ADDR_W-1:0] res_fault_addr,
  output logic [ADDR_W-1:0] res_real_addr
);

  verdict_t verdict;
  logic     accept;

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  dsd_verdict #(
    .ALIGN_FP_CODE(ALIGN_FP_CODE)
  ) u_verdict (
    .kind    (in_kind),
    .cls     (in_class),
    .key     (in_key),
    .verdict (verdict)
  );

  dsd_result_stage #(
    .ADDR_W(ADDR_W)
  ) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .verdict    (verdict),
    .eaddr      (in_eaddr),
    .take       (res_ready),
    .valid      (res_valid),
    .grant      (res_grant),
    .noop       (res_noop),
    .err        (res_err),
    .exc        (res_exc),
    .code       (res_code),
    .status     (res_status),
    .fault_addr (res_fault_addr),
    .real_addr  (res_real_addr)
  );

endmodule

// File: rtl/dsd_access_checker_chk.sv
module dsd_access_checker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_kind,
  input logic [2:0]        in_class,
  input logic              in_key,
  input logic [ADDR_W-1:0] in_eaddr,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_grant,
  input logic              res_noop,
  input logic              res_err,
  input logic [1:0]        res_exc,
  input logic [31:0]       res_code,
  input logic [31:0]       res_status,
  input logic [ADDR_W-1:0] res_fault_addr,
  input logic [ADDR_W-1:0] res_real_addr
);

  logic fire;
  assign fire = in_valid && in_ready;

  p_accept_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_exc) && $stable(res_code)
      && $stable(res_status) && $stable(res_fault_addr) && $stable(res_real_addr)
      && $stable(res_grant) && $stable(res_noop) && $stable(res_err)));

  p_fetch_instr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == 2'b10) |=> (res_exc == 2'd1 && res_code == 32'h1000_0000 && !res_grant));

  p_float_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind[1] == 1'b0 && in_class == 3'd1) |=>
      (res_exc == 2'd3 && res_fault_addr == $past(in_eaddr)));

  p_grant_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == 2'b00 && in_class == 3'd0 && !in_key) |=>
      (res_grant && res_real_addr == $past(in_eaddr)));

  p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0({res_grant, res_noop, res_err, res_exc != 2'd0}));

  p_noop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_noop) |-> (res_code == '0 && res_status == '0 && res_fault_addr == '0));

endmodule

bind dsd_access_checker dsd_access_checker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dsd_access_checker_test.sv
module dsd_access_checker_test;

  localparam int AW = 32;

  typedef struct packed {
    logic        grant;
    logic        noop;
    logic        err;
    logic [1:0]  exc;
    logic [31:0] code;
    logic [31:0] status;
    logic [31:0] faddr;
    logic [31:0] raddr;
    logic [3:0]  req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_kind = '0;
  logic [2:0]    in_class = '0;
  logic          in_key = 1'b0;
  logic [AW-1:0] in_eaddr = '0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic          res_grant, res_noop, res_err;
  logic [1:0]    res_exc;
  logic [31:0]   res_code, res_status;
  logic [AW-1:0] res_fault_addr, res_real_addr;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   cycles = 0;
  exp_t pend[$];

  always #2 clk = ~clk;

  dsd_access_checker uut (.*);

  function automatic exp_t model(input logic [1:0] k, input logic [2:0] c,
                                 input logic key, input logic [31:0] ea);
    exp_t e = '0;
    bit   wr = (k == 2'b01);
    if (k == 2'b10) begin
      e.exc = 2'd1; e.code = 32'h1000_0000; e.req = 4'd1;
    end else if (k == 2'b11) begin
      e.err = 1'b1; e.req = 4'd8;
    end else if (c == 3'd1) begin
      e.exc = 2'd3; e.code = 32'h0000_0010; e.faddr = ea; e.req = 4'd2;
    end else if (c == 3'd2) begin
      e.exc = 2'd2; e.status = wr ? 32'h0600_0000 : 32'h0400_0000; e.faddr = ea; e.req = 4'd3;
    end else if (c == 3'd4) begin
      e.exc = 2'd2; e.status = wr ? 32'h0610_0000 : 32'h0410_0000; e.faddr = ea; e.req = 4'd4;
    end else if (c == 3'd3) begin
      e.noop = 1'b1; e.req = 4'd5;
    end else if (c == 3'd0) begin
      if ((wr && key) || (!wr && !key)) begin
        e.grant = 1'b1; e.raddr = ea; e.req = 4'd6;
      end else begin
        e.exc = 2'd2; e.status = wr ? 32'h0A00_0000 : 32'h0800_0000; e.faddr = ea; e.req = 4'd7;
      end
    end else begin
      e.err = 1'b1; e.req = 4'd8;
    end
    return e;
  endfunction

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  default: return "R9";
    endcase
  endfunction

  task automatic check_bit(input string r, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", r, what, act, exp);
    end
  endtask

  task automatic check_out(input exp_t e);
    exp_t a;
    a = '{res_grant, res_noop, res_err, res_exc, res_code, res_status,
          res_fault_addr, res_real_addr, e.req};
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s result actual=%h expected=%h (R9 hold/order)", tag(e.req), a, e);
    end
  endtask

  // one cycle: drive at negedge, settle, compare, then let posedge act
  task automatic step(input bit v, input logic [1:0] k, input logic [2:0] c,
                      input logic key, input logic [31:0] ea, input bit rdy);
    bit fire, take;
    @(negedge clk);
    in_valid = v; in_kind = k; in_class = c; in_key = key; in_eaddr = ea; res_ready = rdy;
    #1;
    check_bit("R9", "res_valid", res_valid, pend.size() > 0);
    check_bit("R9", "in_ready", in_ready, (pend.size() == 0) || rdy);
    if (pend.size() > 0) check_out(pend[0]);
    take = res_valid && rdy;
    fire = v && in_ready;
    if (take && pend.size() > 0) void'(pend.pop_front());
    if (fire) pend.push_back(model(k, c, key, ea));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R10", "res_valid after reset", res_valid, 1'b0);
    check_bit("R10", "in_ready after reset", in_ready, 1'b1);
    rst_n = 1'b1;
    // directed: every class for read and write, both keys (R1..R8)
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 8; c++)
        for (int y = 0; y < 2; y++)
          step(1'b1, k[1:0], c[2:0], y[0], 32'hC000_0000 + k*256 + c*16 + y, 1'b1);
    // stalls: back-pressure holds result (R9)
    step(1'b1, 2'b00, 3'd0, 1'b0, 32'h1234_5678, 1'b0);
    step(1'b1, 2'b01, 3'd2, 1'b0, 32'h8765_4321, 1'b0);
    step(1'b1, 2'b01, 3'd4, 1'b1, 32'hDEAD_BEEF, 1'b0);
    step(1'b1, 2'b01, 3'd0, 1'b1, 32'hFFFF_FFFF, 1'b1);
    step(1'b0, 2'b00, 3'd0, 1'b0, 32'h0, 1'b1);
    // random mix with random back-pressure
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 2'($urandom), 3'($urandom), 1'($urandom),
           $urandom, ($urandom % 10) < 7);
    for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 3'd0, 1'b0, 32'h0, 1'b1);
    check_bit("R9", "all results delivered", pend.size() == 0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule